// File: doc/BRIEF.md
# Three-Frame Window Move Sequencer

This block moves a group of windows across the screen using only the serial pixel streams of the frame store, without any pixel work by the processors. Each stream beat carries two pixels for the same raster position: one read from the visible (on-screen) memory and one read from the hidden staging memory. For every beat the block chooses what goes to the color converter and emits at most one pixel write, either into the staging memory or back into the on-screen memory. The raster position is tracked inside the block from a start-of-frame marker on the input stream.

When idle, the block shows the on-screen pixel and mirrors it into the staging memory at the same position, so the staging copy is always current. The window manager supplies a signed shift vector, a 256-entry move set and a 256-entry cover set (both indexed by the window identifier), and a cursor-carry flag, then pulses start. From the next frame start the block runs three whole-frame passes. The first pass copies pixels of moving windows into staging memory at the shifted position. The second pass copies pixels of windows allowed to overlap them, unshifted, so stacking order is restored. The third pass displays the staging memory and writes every staging pixel back to the on-screen memory. The block then returns to idle. Repainting of uncovered background is left to the rendering side, which may run during all three passes.

The stream interface is valid/ready and passes back-pressure straight through. `s_ready` equals `m_ready`. A beat is transferred only when `s_valid` and `m_ready` are both high. Without a transfer there is no write and the raster position does not advance. The source must hold a beat stable while it waits.

Top module: `wm_move_seq`

## Requirements
- R1: After reset, `phase` is 0 (idle) and `busy` is low; with no transfer, neither write enable is asserted.
- R2: In phase 0, each transferred beat sends the on-screen pixel to `m_pix` and writes that pixel into staging memory at the current raster position, with the cursor lane enabled.
- R3: A start pulse is accepted only when the block is idle with no move pending. It latches the shift vector, both sets and the cursor flag, raises `busy`, and leaves `phase` at 0 until the next start-of-frame beat. A start pulse while busy changes nothing.
- R4: In phase 1, `m_pix` is the on-screen pixel. A pixel whose window identifier (pixel bits [31:24] at default widths, above the 24 color bits; cursor bits sit above the identifier) is in the move set is written to staging memory at (x+dx, y+dy).
- R5: In phase 1, a pixel whose window identifier is not in the move set causes no staging write.
- R6: A shifted destination with x outside 0..H-1 or y outside 0..V-1 is dropped, not wrapped, and no staging write is issued.
- R7: In phase 2, `m_pix` is the on-screen pixel. A pixel whose window identifier is in the cover set is written to staging memory at its own position; other pixels cause no write.
- R8: In phase 3, `m_pix` is the staging pixel. Each transferred beat writes the staging pixel into on-screen memory at the current position, and there is no staging write.
- R9: `phase` advances only on a transferred start-of-frame beat, in the order 0, 1, 2, 3, 0, one frame per phase. `busy` stays high through phase 3 and drops after the first beat of the following frame.
- R10: The cursor lane enable follows the latched cursor flag for writes in phases 1 to 3, and is always on for idle mirroring.
- R11: `s_ready` follows `m_ready` and `m_valid` follows `s_valid`. With no transfer there is no write and the raster position holds.
- R12: A start-of-frame beat is at position (0,0), even in mid-line. x counts up per transfer and wraps to 0 after H-1, and y then advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a move (pulse) |
| shift_x | input | X_W+1 | Signed horizontal shift |
| shift_y | input | Y_W+1 | Signed vertical shift |
| move_set | input | 2^WID_W | Bit per window identifier: window moves |
| cover_set | input | 2^WID_W | Bit per window identifier: window may overlap movers |
| cursor_en | input | 1 | Carry cursor planes during the move |
| busy | output | 1 | Move pending or in progress |
| phase | output | 2 | Current pass: 0 idle, 1 shifted copy, 2 cover copy, 3 write-back |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted |
| s_sof | input | 1 | Beat is the first pixel of a frame |
| s_os_pix | input | PIX_W | Pixel from on-screen memory |
| s_dm_pix | input | PIX_W | Pixel from staging memory |
| m_valid | output | 1 | Display beat valid |
| m_ready | input | 1 | Color converter ready |
| m_pix | output | PIX_W | Pixel to the color converter |
| dm_we | output | 1 | Staging memory write |
| dm_cur_we | output | 1 | Staging memory cursor lane write |
| dm_x | output | X_W | Staging write column |
| dm_y | output | Y_W | Staging write row |
| dm_wpix | output | PIX_W | Staging write data |
| os_we | output | 1 | On-screen memory write |
| os_cur_we | output | 1 | On-screen memory cursor lane write |
| os_x | output | X_W | On-screen write column |
| os_y | output | Y_W | On-screen write row |
| os_wpix | output | PIX_W | On-screen write data |

## Verification
Full moves are run on a reduced 8 by 4 raster whose pixels carry four window identifiers in a diagonal pattern. Positive, negative and zero shifts are used, so destinations run off each edge. This separates dropped writes from wrapped writes and from correctly shifted ones. The move and cover sets vary from empty to full, so phase 1 and phase 2 selection are judged on their own against the unselected pixels. Stalled beats are mixed in, and start is pulsed with different settings during the move, to show that back-pressure and late commands leave the result unchanged. Each move is followed by an idle frame, which shows the return to mirroring.

// File: rtl/wm_move_pkg.sv
package wm_move_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_COVER = 2'd2,
    PH_BACK  = 2'd3
  } wm_phase_e;

  function automatic wm_phase_e wm_phase_step(input wm_phase_e cur, input logic pend);
    case (cur)
      PH_IDLE:  return pend ? PH_SHIFT : PH_IDLE;
      PH_SHIFT: return PH_COVER;
      PH_COVER: return PH_BACK;
      default:  return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/wm_raster_pos.sv
module wm_raster_pos #(
  parameter int H_ACT = 1280,
  parameter int V_ACT = 1024,
  parameter int X_W   = 11,
  parameter int Y_W   = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           sof,
  output logic [X_W-1:0] cur_x,
  output logic [Y_W-1:0] cur_y
);

  logic [X_W-1:0] x_q;
  logic [Y_W-1:0] y_q;

  assign cur_x = sof ? '0 : x_q;
  assign cur_y = sof ? '0 : y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step) begin
      if (cur_x == X_W'(H_ACT - 1)) begin
        x_q <= '0;
        y_q <= (cur_y == Y_W'(V_ACT - 1)) ? '0 : cur_y + 1'b1;
      end else begin
        x_q <= cur_x + 1'b1;
        y_q <= cur_y;
      end
    end
  end

endmodule

// File: rtl/wm_phase_ctrl.sv
module wm_phase_ctrl
  import wm_move_pkg::*;
#(
  parameter int X_W  = 11,
  parameter int Y_W  = 10,
  parameter int NWID = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [X_W:0]    shift_x,
  input  logic [Y_W:0]    shift_y,
  input  logic [NWID-1:0] move_set,
  input  logic [NWID-1:0] cover_set,
  input  logic            cursor_en,
  input  logic            frame_tick,
  output wm_phase_e       phase_q,
  output wm_phase_e       phase_eff,
  output logic            busy,
  output logic [X_W:0]    lat_sx,
  output logic [Y_W:0]    lat_sy,
  output logic [NWID-1:0] lat_move,
  output logic [NWID-1:0] lat_cover,
  output logic            lat_cur
);

  logic pend_q;
  logic take;

  assign take      = start && (phase_q == PH_IDLE) && !pend_q;
  assign phase_eff = frame_tick ? wm_phase_step(phase_q, pend_q) : phase_q;
  assign busy      = pend_q || (phase_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      pend_q    <= 1'b0;
      lat_sx    <= '0;
      lat_sy    <= '0;
      lat_move  <= '0;
      lat_cover <= '0;
      lat_cur   <= 1'b0;
    end else begin
      if (frame_tick) begin
        phase_q <= phase_eff;
        if (phase_q == PH_IDLE && pend_q) pend_q <= 1'b0;
      end
      if (take) begin
        pend_q    <= 1'b1;
        lat_sx    <= shift_x;
        lat_sy    <= shift_y;
        lat_move  <= move_set;
        lat_cover <= cover_set;
        lat_cur   <= cursor_en;
      end
    end
  end

endmodule

// File: rtl/wm_pixel_route.sv
module wm_pixel_route
  import wm_move_pkg::*;
#(
  parameter int H_ACT       = 1280,
  parameter int V_ACT       = 1024,
  parameter int X_W         = 11,
  parameter int Y_W         = 10,
  parameter int COLOR_W     = 24,
  parameter int WID_W       = 8,
  parameter int PIX_W       = 36,
  parameter int CUR_SUPPORT = 1
) (
  input  wm_phase_e              phase_eff,
  input  logic                   xfer,
  input  logic [X_W-1:0]         cur_x,
  input  logic [Y_W-1:0]         cur_y,
  input  logic [X_W:0]           sx,
  input  logic [Y_W:0]           sy,
  input  logic [(1<<WID_W)-1:0]  mv_set,
  input  logic [(1<<WID_W)-1:0]  cv_set,
  input  logic                   cur_en,
  input  logic [PIX_W-1:0]       os_pix,
  input  logic [PIX_W-1:0]       dm_pix,
  output logic [PIX_W-1:0]       m_pix,
  output logic                   dm_we,
  output logic                   dm_cur_we,
  output logic [X_W-1:0]         dm_x,
  output logic [Y_W-1:0]         dm_y,
  output logic [PIX_W-1:0]       dm_wpix,
  output logic                   os_we,
  output logic                   os_cur_we,
  output logic [X_W-1:0]         os_x,
  output logic [Y_W-1:0]         os_y,
  output logic [PIX_W-1:0]       os_wpix
);

  localparam int DX_W = X_W + 3;
  localparam int DY_W = Y_W + 3;

  logic [WID_W-1:0]       wid;
  logic signed [DX_W-1:0] tx;
  logic signed [DY_W-1:0] ty;
  logic                   in_frame;
  logic                   lane_on;

  assign wid = os_pix[COLOR_W +: WID_W];
  assign tx  = $signed({3'b000, cur_x}) + $signed({{2{sx[X_W]}}, sx});
  assign ty  = $signed({3'b000, cur_y}) + $signed({{2{sy[Y_W]}}, sy});
  assign in_frame = (tx >= 0) && (tx < $signed(DX_W'(H_ACT)))
                 && (ty >= 0) && (ty < $signed(DY_W'(V_ACT)));

  if (CUR_SUPPORT != 0) begin : g_lane
    assign lane_on = cur_en;
  end else begin : g_nolane
    assign lane_on = 1'b0;
  end

  always_comb begin
    m_pix     = os_pix;
    dm_we     = 1'b0;
    dm_cur_we = 1'b0;
    dm_x      = cur_x;
    dm_y      = cur_y;
    dm_wpix   = os_pix;
    os_we     = 1'b0;
    os_cur_we = 1'b0;
    os_x      = cur_x;
    os_y      = cur_y;
    os_wpix   = dm_pix;
    case (phase_eff)
      PH_IDLE: begin
        dm_we     = xfer;
        dm_cur_we = xfer;
      end
      PH_SHIFT: begin
        dm_we     = xfer && mv_set[wid] && in_frame;
        dm_cur_we = xfer && mv_set[wid] && in_frame && lane_on;
        dm_x      = tx[X_W-1:0];
        dm_y      = ty[Y_W-1:0];
      end
      PH_COVER: begin
        dm_we     = xfer && cv_set[wid];
        dm_cur_we = xfer && cv_set[wid] && lane_on;
      end
      default: begin
        m_pix     = dm_pix;
        os_we     = xfer;
        os_cur_we = xfer && lane_on;
      end
    endcase
  end

endmodule

// File: rtl/wm_move_seq.sv
module wm_move_seq
  import wm_move_pkg::*;
#(
  parameter int H_ACT       = 1280,
  parameter int V_ACT       = 1024,
  parameter int COLOR_W     = 24,
  parameter int WID_W       = 8,
  parameter int CUR_W       = 4,
  parameter int CUR_SUPPORT = 1,
  localparam int X_W   = $clog2(H_ACT),
  localparam int Y_W   = $clog2(V_ACT),
  localparam int PIX_W = COLOR_W + WID_W + CUR_W,
  localparam int NWID  = 1 << WID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [X_W:0]     shift_x,
  input  logic [Y_W:0]     shift_y,
  input  logic [NWID-1:0]  move_set,
  input  logic [NWID-1:0]  cover_set,
  input  logic             cursor_en,
  output logic             busy,
  output logic [1:0]       phase,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_sof,
  input  logic [PIX_W-1:0] s_os_pix,
  input  logic [PIX_W-1:0] s_dm_pix,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_pix,
  output logic             dm_we,
  output logic             dm_cur_we,
  output logic [X_W-1:0]   dm_x,
  output logic [Y_W-1:0]   dm_y,
  output logic [PIX_W-1:0] dm_wpix,
  output logic             os_we,
  output logic             os_cur_we,
  output logic [X_W-1:0]   os_x,
  output logic [Y_W-1:0]   os_y,
  output logic [PIX_W-1:0] os_wpix
);

  logic            xfer;
  logic            frame_tick;
  logic [X_W-1:0]  cur_x;
  logic [Y_W-1:0]  cur_y;
  wm_phase_e       phase_q;
  wm_phase_e       phase_eff;
  logic [X_W:0]    lat_sx;
  logic [Y_W:0]    lat_sy;
  logic [NWID-1:0] lat_move;
  logic [NWID-1:0] lat_cover;
  logic            lat_cur;

  assign s_ready    = m_ready;
  assign m_valid    = s_valid;
  assign xfer       = s_valid && m_ready;
  assign frame_tick = xfer && s_sof;
  assign phase      = phase_q;

  wm_raster_pos #(.H_ACT(H_ACT), .V_ACT(V_ACT), .X_W(X_W), .Y_W(Y_W)) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (xfer),
    .sof   (s_sof),
    .cur_x (cur_x),
    .cur_y (cur_y)
  );

  wm_phase_ctrl #(.X_W(X_W), .Y_W(Y_W), .NWID(NWID)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .shift_x    (shift_x),
    .shift_y    (shift_y),
    .move_set   (move_set),
    .cover_set  (cover_set),
    .cursor_en  (cursor_en),
    .frame_tick (frame_tick),
    .phase_q    (phase_q),
    .phase_eff  (phase_eff),
    .busy       (busy),
    .lat_sx     (lat_sx),
    .lat_sy     (lat_sy),
    .lat_move   (lat_move),
    .lat_cover  (lat_cover),
    .lat_cur    (lat_cur)
  );

  wm_pixel_route #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .X_W(X_W), .Y_W(Y_W),
    .COLOR_W(COLOR_W), .WID_W(WID_W), .PIX_W(PIX_W), .CUR_SUPPORT(CUR_SUPPORT)
  ) u_route (
    .phase_eff (phase_eff),
    .xfer      (xfer),
    .cur_x     (cur_x),
    .cur_y     (cur_y),
    .sx        (lat_sx),
    .sy        (lat_sy),
    .mv_set    (lat_move),
    .cv_set    (lat_cover),
    .cur_en    (lat_cur),
    .os_pix    (s_os_pix),
    .dm_pix    (s_dm_pix),
    .m_pix     (m_pix),
    .dm_we     (dm_we),
    .dm_cur_we (dm_cur_we),
    .dm_x      (dm_x),
    .dm_y      (dm_y),
    .dm_wpix   (dm_wpix),
    .os_we     (os_we),
    .os_cur_we (os_cur_we),
    .os_x      (os_x),
    .os_y      (os_y),
    .os_wpix   (os_wpix)
  );

endmodule

// File: rtl/wm_move_seq_chk.sv
module wm_move_seq_chk #(
  parameter int H_ACT = 1280,
  parameter int V_ACT = 1024,
  parameter int X_W   = 11,
  parameter int Y_W   = 10,
  parameter int PIX_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [1:0]       phase,
  input logic             s_valid,
  input logic             s_sof,
  input logic             m_ready,
  input logic [PIX_W-1:0] s_os_pix,
  input logic [PIX_W-1:0] m_pix,
  input logic             dm_we,
  input logic [X_W-1:0]   dm_x,
  input logic [Y_W-1:0]   dm_y,
  input logic [PIX_W-1:0] dm_wpix,
  input logic             os_we,
  input logic [X_W-1:0]   cur_x,
  input logic [Y_W-1:0]   cur_y
);

  AST_NO_WRITE_WITHOUT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && m_ready) |-> (!dm_we && !os_we)); // R11

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> !os_we); // R8

  AST_BACK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && !s_sof) |-> (!dm_we && (os_we == (s_valid && m_ready)))); // R8

  AST_IDLE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && !s_sof && s_valid && m_ready)
      |-> (dm_we && dm_wpix == s_os_pix && dm_x == cur_x && dm_y == cur_y)); // R2

  AST_DEST_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> (int'(dm_x) < H_ACT && int'(dm_y) < V_ACT)); // R6

  AST_BUSY_COVERS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd0) |-> busy); // R9

  AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && m_ready && s_sof) |=> $stable(phase)); // R9

  AST_COVER_UNSHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && !s_sof && dm_we) |-> (dm_x == cur_x && dm_y == cur_y)); // R7

  AST_SHOW_ONSCREEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == 2'd1 || phase == 2'd2) && !s_sof) |-> (m_pix == s_os_pix)); // R4

endmodule

bind wm_move_seq wm_move_seq_chk #(
  .H_ACT(H_ACT), .V_ACT(V_ACT), .X_W(X_W), .Y_W(Y_W), .PIX_W(PIX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .phase    (phase),
  .s_valid  (s_valid),
  .s_sof    (s_sof),
  .m_ready  (m_ready),
  .s_os_pix (s_os_pix),
  .m_pix    (m_pix),
  .dm_we    (dm_we),
  .dm_x     (dm_x),
  .dm_y     (dm_y),
  .dm_wpix  (dm_wpix),
  .os_we    (os_we),
  .cur_x    (cur_x),
  .cur_y    (cur_y)
);

// File: tb/wm_move_seq_bench.sv
module wm_move_seq_bench;

  localparam int H = 8;
  localparam int V = 4;
  localparam int XW = 3;
  localparam int YW = 2;
  localparam int PW = 36;

  // entry: {dx[3:0] signed, dy[2:0] signed, move mask wid1..4, cover mask wid1..4, cursor, stall}
  localparam logic [16:0] TBL [4] = '{
    {4'd1,  3'd1, 4'b0011, 4'b0100, 1'b1, 1'b0},
    {4'hE,  3'd0, 4'b0001, 4'b1010, 1'b0, 1'b1},
    {4'd3,  3'h7, 4'b1111, 4'b0000, 1'b1, 1'b1},
    {4'd0,  3'd2, 4'b0100, 4'b1111, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [XW:0] shift_x = '0;
  logic [YW:0] shift_y = '0;
  logic [255:0] move_set = '0;
  logic [255:0] cover_set = '0;
  logic cursor_en = 1'b0;
  logic busy;
  logic [1:0] phase;
  logic s_valid = 1'b0;
  logic s_ready;
  logic s_sof = 1'b0;
  logic [PW-1:0] s_os_pix = '0;
  logic [PW-1:0] s_dm_pix = '0;
  logic m_valid;
  logic m_ready = 1'b1;
  logic [PW-1:0] m_pix;
  logic dm_we, dm_cur_we, os_we, os_cur_we;
  logic [XW-1:0] dm_x, os_x;
  logic [YW-1:0] dm_y, os_y;
  logic [PW-1:0] dm_wpix, os_wpix;

  int n_chk = 0;
  int n_bad = 0;
  int ref_dx, ref_dy;
  logic [3:0] ref_mv, ref_cv;
  logic ref_ce;

  always #4 clk = ~clk;

  wm_move_seq #(.H_ACT(H), .V_ACT(V)) u_wm_move_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .shift_x(shift_x), .shift_y(shift_y),
    .move_set(move_set), .cover_set(cover_set), .cursor_en(cursor_en),
    .busy(busy), .phase(phase), .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof),
    .s_os_pix(s_os_pix), .s_dm_pix(s_dm_pix), .m_valid(m_valid), .m_ready(m_ready),
    .m_pix(m_pix), .dm_we(dm_we), .dm_cur_we(dm_cur_we), .dm_x(dm_x), .dm_y(dm_y),
    .dm_wpix(dm_wpix), .os_we(os_we), .os_cur_we(os_cur_we), .os_x(os_x), .os_y(os_y),
    .os_wpix(os_wpix)
  );

  function automatic logic [PW-1:0] os_px(input int x, input int y);
    return {4'(x + y), 8'(((x + 2 * y) % 4) + 1), 8'(y), 8'(x), 8'hA5};
  endfunction

  function automatic logic [PW-1:0] dm_px(input int x, input int y);
    return {4'(~x), 8'd9, 8'h3C, 8'(x * y), 8'(y)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic beat(input int x, input int y, input bit sof, input int ph,
                      input bit stall, input string idle_tag);
    logic [PW-1:0] o, d;
    int w, tx, ty;
    bit e_dw, e_dc, e_ow, e_oc, inr;
    int ex, ey;
    string dtag;
    @(negedge clk);
    o = os_px(x, y);
    d = dm_px(x, y);
    s_os_pix = o; s_dm_pix = d; s_sof = sof; s_valid = 1'b1;
    if (stall) begin
      m_ready = 1'b0;
      #2;
      chk("R11 stall", {60'd0, s_ready, dm_we, os_we, m_valid}, 64'h1);
      @(negedge clk);
    end
    m_ready = 1'b1;
    #2;
    w = int'(o[31:24]);
    e_dw = 0; e_dc = 0; e_ow = 0; e_oc = 0; ex = x; ey = y; dtag = idle_tag;
    case (ph)
      0: begin e_dw = 1; e_dc = 1; end
      1: begin
        tx = x + ref_dx; ty = y + ref_dy;
        inr = (tx >= 0 && tx < H && ty >= 0 && ty < V);
        e_dw = ref_mv[w-1] && inr; e_dc = e_dw && ref_ce; ex = tx; ey = ty;
        dtag = !ref_mv[w-1] ? "R5" : (!inr ? "R6" : "R4");
      end
      2: begin e_dw = ref_cv[w-1]; e_dc = e_dw && ref_ce; dtag = "R7"; end
      default: begin e_ow = 1; e_oc = ref_ce; dtag = "R8"; end
    endcase
    chk(ph == 3 ? "R8 display" : (ph == 0 ? "R2 display" : "R4 display"),
        {28'd0, m_pix}, {28'd0, (ph == 3) ? d : o});
    chk(dtag, {22'd0, dm_we, dm_we ? {dm_x, dm_y, dm_wpix} : 41'd0},
        {22'd0, e_dw, e_dw ? {3'(ex), 2'(ey), o} : 41'd0});
    chk("R8 writeback", {22'd0, os_we, os_we ? {os_x, os_y, os_wpix} : 41'd0},
        {22'd0, e_ow, e_ow ? {3'(x), 2'(y), d} : 41'd0});
    chk("R10 cursor lane", {62'd0, dm_cur_we, os_cur_we}, {62'd0, e_dc, e_oc});
  endtask

  task automatic run_move(input logic [16:0] e);
    int i;
    ref_dx = int'($signed(e[16:13]));
    ref_dy = int'($signed(e[12:10]));
    ref_mv = e[9:6];
    ref_cv = e[5:2];
    ref_ce = e[1];
    @(negedge clk);
    shift_x = e[16:13]; shift_y = e[12:10]; cursor_en = e[1];
    move_set = '0; cover_set = '0;
    for (int k = 1; k <= 4; k++) begin
      move_set[k] = ref_mv[k-1];
      cover_set[k] = ref_cv[k-1];
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #2;
    chk("R3 accepted", {62'd0, busy, phase == 2'd0}, 64'h3);
    for (int p = 0; p < 3; p++) beat(p, 0, 0, 0, 0, "R3 pre-frame");
    for (int k = 0; k < 4; k++) begin
      i = 0;
      @(negedge clk);
      if (k < 3) begin
        start = 1'b1; shift_x = '0; shift_y = '0; cursor_en = ~e[1];
        move_set = '1; cover_set = '1;
      end else begin
        start = 1'b0;
      end
      for (int y = 0; y < V; y++) begin
        for (int x = 0; x < H; x++) begin
          beat(x, y, (x == 0 && y == 0), (k < 3) ? k + 1 : 0,
               e[0] && ((x + y) % 5 == 0), "R2");
          if (i == 1) chk("R9 R3 phase", {61'd0, busy, phase},
                          {61'd0, k < 3, 2'((k < 3) ? k + 1 : 0)});
          i++;
        end
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset", {60'd0, busy, phase, dm_we | os_we}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk("R1 after release", {60'd0, busy, phase, dm_we | os_we}, 64'h0);
    chk("R11 ready follows", {62'd0, s_ready, m_valid}, 64'h2);

    for (int t = 0; t < 4; t++) run_move(TBL[t]);

    beat(0, 0, 1, 0, 0, "R12");
    for (int i = 1; i < 10; i++) beat(i % H, i / H, 0, 0, 0, "R12 wrap");
    beat(0, 0, 1, 0, 0, "R12 midline sof");
    beat(1, 0, 0, 0, 1, "R12 after sof");
    @(negedge clk);
    s_valid = 1'b0;
    #2;
    chk("R9 final idle", {62'd0, busy, phase != 2'd0}, 64'h0);

    summary();
    $finish;
  end

endmodule